// File: doc/BRIEF.md
# Sector ECC Syndrome Corrector

This block settles the outcome of a single-error-correcting line/column parity check over a 512-byte flash sector. It receives two 24-bit ECC words: the one stored alongside the sector in flash, and the one recomputed over the data as it was read back. It XORs them into a syndrome and sorts the result into one of five outcomes: clean, blank page, corrected data bit, corrected ECC field, or uncorrectable. When one data bit has flipped, the block repairs that bit in the external sector buffer. It does this with one read followed by one write on a synchronous memory port.

A one-cycle `start` pulse latches both ECC words. After that, the block runs alone and raises `done` for exactly one cycle. In that cycle, `status`, `err_addr` and `err_bit` carry the outcome. Each ECC word is packed with byte 0 in bits [7:0], byte 1 in bits [15:8] and byte 2 in bits [23:16].

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: The syndrome is `ecc_stored ^ ecc_calc`. A zero syndrome reports status 0 (clean) and leaves the buffer unwritten, even when the stored word is 0xFFFFFF.
- R2: A nonzero syndrome with `ecc_stored == 24'hFFFFFF` reports status 1 (blank) and does not write. This holds even when the syndrome has the correctable shape.
- R3: A syndrome is treated as a data error only when, in each of its three bytes, bits 1/0, 3/2, 5/4 and 7/6 differ from each other.
- R4: For a data error, the failing bit index `err_bit` is {syndrome bit 23, bit 21, bit 19}, most significant first.
- R5: For a data error, `err_addr` is {syn[17], syn[15], syn[13], syn[11], syn[9], syn[7], syn[5], syn[3], syn[1]}, most significant first.
- R6: A data error reports status 2. The block reads `err_addr`, then one cycle later writes back the returned byte with bit `err_bit` inverted. That is the only memory write of the run.
- R7: A syndrome with exactly one bit set (and not covered by R1 or R2) reports status 3 and does not write.
- R8: Every other nonzero syndrome reports status 4 (uncorrectable) and does not write.
- R9: `done` is high for one cycle. It rises 2 cycles after the `start` sample edge's cycle for outcomes that do not write, and 4 cycles after for a data correction.
- R10: `start` is ignored while `busy` is high. Inputs that change during a run do not affect that run.
- R11: After reset, `busy`, `done`, `mem_re` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check; ECC words are latched on this edge |
| ecc_stored | input | 24 | ECC word read from flash |
| ecc_calc | input | 24 | ECC word recomputed over the data |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle pulse; result outputs valid |
| status | output | 3 | 0 clean, 1 blank, 2 data fixed, 3 ECC fixed, 4 uncorrectable |
| err_addr | output | 9 | Byte address decoded from the syndrome |
| err_bit | output | 3 | Bit index decoded from the syndrome |
| mem_addr | output | 9 | Sector buffer address |
| mem_re | output | 1 | Buffer read strobe (data returns next cycle) |
| mem_we | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write data |
| mem_rdata | input | 8 | Buffer read data, one cycle after `mem_re` |

## Verification
Two pairs of functions can meet in a single cycle or evaluation. The first pair is the done pulse of one run and a new `start`. The bench provokes this by holding `start` high through a whole run while changing the ECC inputs, then checks that exactly one result appears and that it reflects the first latched pair. The second pair is the blank-page test and the data-error test, which both match when the stored word is all ones and the syndrome has the correctable shape. The bench judges this case by requiring status 1 and an unchanged buffer.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;
  localparam int ECC_W  = 24;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int BIT_W  = 3;
  localparam int ECC_BYTES = ECC_W / 8;

  typedef enum logic [2:0] {
    ST_CLEAN     = 3'd0,
    ST_BLANK     = 3'd1,
    ST_FIX_DATA  = 3'd2,
    ST_FIX_ECC   = 3'd3,
    ST_FATAL     = 3'd4
  } ecc_status_e;
endpackage

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_corr_pkg::*;
(
  input  logic [ECC_W-1:0]  stored,
  input  logic [ECC_W-1:0]  calc,
  output logic [ECC_W-1:0]  syn,
  output ecc_status_e       cls,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [BIT_W-1:0]  bit_idx
);
  logic [ECC_BYTES-1:0] pair_ok;

  assign syn = stored ^ calc;

  // Each byte must show complementary adjacent pairs
  for (genvar g = 0; g < ECC_BYTES; g++) begin : g_pair
    logic [7:0] d;
    assign d = syn[8*g +: 8];
    assign pair_ok[g] = ((d ^ (d >> 1)) & 8'h55) == 8'h55;
  end

  assign byte_addr = {syn[17], syn[15], syn[13], syn[11], syn[9],
                      syn[7],  syn[5],  syn[3],  syn[1]};
  assign bit_idx   = {syn[23], syn[21], syn[19]};

  always_comb begin
    if (syn == '0)                          cls = ST_CLEAN;
    else if (stored == {ECC_W{1'b1}})       cls = ST_BLANK;
    else if (&pair_ok)                      cls = ST_FIX_DATA;
    else if ((syn & (syn - 1'b1)) == '0)    cls = ST_FIX_ECC;
    else                                    cls = ST_FATAL;
  end
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_corr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ECC_W-1:0]  ecc_stored,
  input  logic [ECC_W-1:0]  ecc_calc,
  output logic [ECC_W-1:0]  stored_q,
  output logic [ECC_W-1:0]  calc_q,
  input  ecc_status_e       cls,
  input  logic [ADDR_W-1:0] cls_addr,
  input  logic [BIT_W-1:0]  cls_bit,
  output logic              busy,
  output logic              done,
  output ecc_status_e       status_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BIT_W-1:0]  bit_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_READ, S_WRITE, S_FIN} seq_e;
  seq_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      stored_q <= '0;
      calc_q   <= '0;
      status_q <= ST_CLEAN;
      addr_q   <= '0;
      bit_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          stored_q <= ecc_stored;
          calc_q   <= ecc_calc;
          state    <= S_EVAL;
        end
        S_EVAL: begin
          status_q <= cls;
          addr_q   <= cls_addr;
          bit_q    <= cls_bit;
          state    <= (cls == ST_FIX_DATA) ? S_READ : S_FIN;
        end
        S_READ:  state <= S_WRITE;
        S_WRITE: state <= S_FIN;
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign mem_re    = (state == S_READ);
  assign mem_we    = (state == S_WRITE);
  assign mem_addr  = addr_q;
  assign mem_wdata = mem_rdata ^ (DATA_W'(1) << bit_q);

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_re) && mem_addr == $past(mem_addr)); // R6
  AST_WRITE_ONLY_DATA: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> status_q == ST_FIX_DATA); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(stored_q) && $stable(calc_q)); // R10
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_corr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ECC_W-1:0]  ecc_stored,
  input  logic [ECC_W-1:0]  ecc_calc,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status,
  output logic [ADDR_W-1:0] err_addr,
  output logic [BIT_W-1:0]  err_bit,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [ECC_W-1:0]  stored_q, calc_q, syn;
  ecc_status_e       cls, status_q;
  logic [ADDR_W-1:0] cls_addr;
  logic [BIT_W-1:0]  cls_bit;

  ecc_syn_classify u_cls (
    .stored    (stored_q),
    .calc      (calc_q),
    .syn       (syn),
    .cls       (cls),
    .byte_addr (cls_addr),
    .bit_idx   (cls_bit)
  );

  ecc_fix_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ecc_stored (ecc_stored),
    .ecc_calc   (ecc_calc),
    .stored_q   (stored_q),
    .calc_q     (calc_q),
    .cls        (cls),
    .cls_addr   (cls_addr),
    .cls_bit    (cls_bit),
    .busy       (busy),
    .done       (done),
    .status_q   (status_q),
    .addr_q     (err_addr),
    .bit_q      (err_bit),
    .mem_addr   (mem_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
  );

  assign status = status_q;

  AST_DATA_SYN_WEIGHT: assert property (@(posedge clk) disable iff (rst)
    (done && status == 3'd2) |-> $countones(syn) == 12); // R3
  AST_BLANK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> stored_q != {ECC_W{1'b1}}); // R2
endmodule

// File: tb/ecc_syndrome_corrector_tb_top.sv
module ecc_syndrome_corrector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [23:0] ecc_stored = '0, ecc_calc = '0;
  logic busy, done, mem_re, mem_we;
  logic [2:0] status, err_bit;
  logic [8:0] err_addr, mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;

  always #4 clk = ~clk; // 125 MHz

  ecc_syndrome_corrector dut_i (
    .clk(clk), .rst(rst), .start(start), .ecc_stored(ecc_stored), .ecc_calc(ecc_calc),
    .busy(busy), .done(done), .status(status), .err_addr(err_addr), .err_bit(err_bit),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  logic [7:0] mem  [512];
  logic [7:0] gold [512];
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  int checks = 0, fails = 0, cyc = 0, wr_cnt = 0, done_cnt = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [2:0] st; logic [8:0] a; logic [2:0] b;
    int lat; int wr; int sc; string req;
  } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pk(input logic o3, o2, o1, o0);
    return {o3, ~o3, o2, ~o2, o1, ~o1, o0, ~o0};
  endfunction

  // Correctable-shape syndrome for a given byte address and bit index (R3-R5)
  function automatic logic [23:0] mk(input logic [8:0] a, input logic [2:0] b);
    return {pk(b[2], b[1], b[0], a[8]), pk(a[7], a[6], a[5], a[4]), pk(a[3], a[2], a[1], a[0])};
  endfunction

  // Monitor: pops scoreboard entries on each done pulse
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) wr_cnt++;
      if (done) begin
        done_cnt++;
        if (q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          chk(status == it.st, it.req, "status", status, it.st);
          chk(cyc - it.sc == it.lat, "R9", "latency", cyc - it.sc, it.lat);
          chk(wr_cnt == it.wr, it.req, "write count", wr_cnt, it.wr);
          if (it.st == 3'd2) begin
            chk(err_addr == it.a, "R5", "byte address", err_addr, it.a);
            chk(err_bit == it.b, "R4", "bit index", err_bit, it.b);
          end
        end
        wr_cnt = 0;
      end
    end
  end

  task automatic check_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== gold[i]) bad++;
    chk(bad == 0, req, "buffer mismatches", bad, 0);
  endtask

  task automatic run(input logic [23:0] s, input logic [23:0] c, input logic [2:0] st,
                     input logic [8:0] a, input logic [2:0] b, input string req);
    item_t it;
    bit fix = (st == 3'd2);
    if (fix) gold[a] = gold[a] ^ (8'd1 << b);
    @(negedge clk);
    ecc_stored = s; ecc_calc = c; start = 1'b1;
    it.st = st; it.a = a; it.b = b; it.lat = fix ? 4 : 2; it.wr = fix ? 1 : 0;
    it.sc = cyc; it.req = req;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    check_mem(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'(i * 7 + 3);
      gold[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R11", "idle after reset",
        {busy, done, mem_re, mem_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R11", "idle after release", {busy, done}, 0);

    run(24'h123456, 24'h123456, 3'd0, 0, 0, "R1");
    run(24'hFFFFFF, 24'hFFFFFF, 3'd0, 0, 0, "R1");
    run(24'hFFFFFF, 24'h00A5C3, 3'd1, 0, 0, "R2");
    run(24'hFFFFFF, 24'hFFFFFF ^ mk(9'h0C4, 3'd6), 3'd1, 0, 0, "R2");
    run(24'h000000 ^ mk(9'h000, 3'd0), 24'h000000, 3'd2, 9'h000, 3'd0, "R6");
    run(24'h5A3C00 ^ mk(9'h1FF, 3'd7), 24'h5A3C00, 3'd2, 9'h1FF, 3'd7, "R6");
    run(24'h0F0F0F ^ mk(9'h155, 3'd5), 24'h0F0F0F, 3'd2, 9'h155, 3'd5, "R5");
    run(24'h777777 ^ mk(9'h0AA, 3'd2), 24'h777777, 3'd2, 9'h0AA, 3'd2, "R4");
    run(24'h000000 ^ mk(9'h0AA, 3'd2), 24'h000000, 3'd2, 9'h0AA, 3'd2, "R3");
    run(24'h000001, 24'h000000, 3'd3, 0, 0, "R7");
    run(24'h800000 ^ 24'h13579B, 24'h13579B, 3'd3, 0, 0, "R7");
    run(24'h001000, 24'h000000, 3'd3, 0, 0, "R7");
    run(24'h000003, 24'h000000, 3'd4, 0, 0, "R8");
    run(mk(9'h033, 3'd1) ^ 24'h000001, 24'h000000, 3'd4, 0, 0, "R3");
    run(24'hFFFFFE, 24'hFFFFFE ^ 24'hFFFFFF, 3'd4, 0, 0, "R8");

    // R10: start held through a run while inputs change
    begin
      item_t it;
      @(negedge clk);
      ecc_stored = 24'h000100; ecc_calc = 24'h000000; start = 1'b1;
      it.st = 3'd3; it.a = 0; it.b = 0; it.lat = 2; it.wr = 0; it.sc = cyc; it.req = "R10";
      q.push_back(it);
      @(negedge clk);
      ecc_stored = mk(9'h010, 3'd3);
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (8) @(negedge clk);
      chk(q.size() == 0, "R10", "pending results", q.size(), 0);
      check_mem("R10");
    end
    chk(done_cnt == 16, "R10", "total done pulses", done_cnt, 16);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule